// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block carries out the address phase of an I2C target at the level of whole bytes. An external bit shifter passes it one-cycle strobes for START and STOP conditions, plus each received byte with a valid strobe. The recognizer checks the address bytes against an own address and a mode select. It then asks the shifter to drive an acknowledge for each address byte it accepts. It also reports whether the target is selected, and which way the data will flow.

Two addressing schemes are supported. In the short scheme a single byte holds a 7-bit address and the direction bit. In the long scheme a header byte starts with the fixed pattern 11110, followed by the two top address bits and the direction bit; a second byte then holds the low eight address bits. The long scheme also lets a master read from a target it has just fully addressed: it issues a repeated START and resends only the header byte, this time with the read bit set. The mode select and own address are captured at every START, so changing them during a transfer does not disturb it.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, ack_req_o, matched_o and dir_rd_o are 0, and received bytes are ignored until a START has been seen.
- R2: In 7-bit mode, suppose the first byte after START has bits 7:1 equal to own address bits 6:0. Then ack_req_o is 1 in the cycle after its byte_valid_i, matched_o becomes 1, and dir_rd_o takes byte bit 0 (1 = master reads, 0 = master writes).
- R3: In 7-bit mode, a first byte whose bits 7:1 differ from the own address gets no acknowledge and no match. So does a first byte whose bits 7:3 are 11110, whatever the own address is. Every byte after it is ignored until the next START.
- R4: In 10-bit mode, a first byte whose bits 7:3 are 11110 and whose bits 2:1 equal own address bits 9:8 is acknowledged. matched_o stays 0 while the second byte is awaited.
- R5: In 10-bit mode, a second byte equal to own address bits 7:0 is acknowledged. matched_o becomes 1 and dir_rd_o takes bit 0 of the first byte. A second byte that differs gets no acknowledge, and the block ignores the bus until the next START.
- R6: In 10-bit mode, a first byte without the 11110 prefix, or with bits 2:1 unequal to own address bits 9:8, gets no acknowledge. Later bytes are ignored until the next START.
- R7: After a full 10-bit match, a repeated START followed by the same first byte with bit 0 = 1 is acknowledged and sets matched_o = 1 and dir_rd_o = 1 at once, with no second byte. If that byte has bit 0 = 0, it is handled as a fresh 10-bit first byte (R4).
- R8: A STOP clears matched_o and dir_rd_o in the following cycle, and so does a START. The only way to select the target again is a new address match, including the R7 re-select.
- R9: The mode select and own address are sampled at START. Changes to them between START and the address bytes have no effect on that transfer.
- R10: ack_req_o is high for exactly one cycle per accepted address byte: the cycle after that byte's valid strobe. It stays 0 for mismatching bytes and for bytes after the target is selected.
- R11: A START and a STOP in the same cycle act as a START. A byte whose valid strobe coincides with START or STOP is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: START or repeated START detected |
| stop_i | input | 1 | One-cycle strobe: STOP detected |
| byte_valid_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte, bit 7 first on the wire |
| cfg_ten_bit_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit addressing |
| cfg_own_addr_i | input | 10 | Own address; 7-bit mode uses bits 6:0 |
| ack_req_o | output | 1 | Request to acknowledge the byte just received |
| matched_o | output | 1 | Target is addressed for the current transfer |
| dir_rd_o | output | 1 | Latched direction: 1 = master reads, 0 = master writes |

## Verification
The bench builds the block with the default widths from the package: 8-bit bytes and a 10-bit address. These widths fix where the 11110 prefix and the bits A9:A8 sit in the header byte. As a result the bench can reach the short-mode reserved-prefix rejection, every 10-bit header and low-byte mismatch, and the repeated-START read re-select, in both of its outcomes. It also changes the configuration inputs between START and the address bytes, and it drives START, STOP and valid strobes in the same cycle to exercise their priority.

// File: rtl/i2c_am_pkg.sv
// Package: shared constants and types for the I2C address recognizer.
// Assumes bytes arrive whole from an external shifter; widths follow the bus.
package i2c_am_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 10;
    localparam int SHORT_W   = 7;
    localparam int PREFIX_W  = 5;
    localparam int HI_W      = ADDR_W - BYTE_W;
    localparam logic [PREFIX_W-1:0] TEN_PREFIX = 5'b11110;

    // Address-phase sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // ignore bus until START
        ST_FIRST  = 2'd1,   // await first address byte
        ST_SECOND = 2'd2,   // await 10-bit low address byte
        ST_ACTIVE = 2'd3    // selected, data phase (handled elsewhere)
    } am_state_e;

    // Configuration captured at START
    typedef struct packed {
        logic              ten_mode;
        logic [ADDR_W-1:0] addr;
    } am_cfg_t;

endpackage

// File: rtl/i2c_am_cfg_latch.sv
// Module: captures mode select and own address on each START strobe.
// Assumes: configuration inputs may change at any time; only START loads them.
module i2c_am_cfg_latch
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ten_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output am_cfg_t           cfg_o
);

    am_cfg_t cfg_q;

    // Load the configuration snapshot on START, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (start_i) begin
            cfg_q.ten_mode <= ten_mode_i;
            cfg_q.addr     <= addr_i;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/i2c_am_cmp.sv
// Module: combinational comparison of a received byte against the captured
// own address. Produces the short-address hit, the 10-bit header hit and
// the 10-bit low-byte hit. Assumes cfg_i is stable while bytes arrive.
module i2c_am_cmp
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  am_cfg_t           cfg_i,
    output logic              hit_short_o,
    output logic              hit_hdr_o,
    output logic              hit_low_o,
    output logic              rd_bit_o
);

    logic prefix_seen;
    logic hi_equal;
    logic short_equal;

    // Decode the header prefix and field equalities
    always_comb begin
        prefix_seen = (byte_i[BYTE_W-1 -: PREFIX_W] == TEN_PREFIX);
        hi_equal    = (byte_i[HI_W:1] == cfg_i.addr[ADDR_W-1:BYTE_W]);
        short_equal = (byte_i[BYTE_W-1:1] == cfg_i.addr[SHORT_W-1:0]);
    end

    // Short address may never match the reserved 10-bit prefix
    always_comb begin
        hit_short_o = short_equal && !prefix_seen;
        hit_hdr_o   = prefix_seen && hi_equal;
        hit_low_o   = (byte_i == cfg_i.addr[BYTE_W-1:0]);
        rd_bit_o    = byte_i[0];
    end

endmodule

// File: rtl/i2c_am_seq.sv
// Module: address-phase sequencer. Steps through first/second address bytes,
// raises a one-cycle acknowledge request per accepted byte, latches match and
// direction, and arms a repeated-START read re-select after a full 10-bit
// match. Assumes START/STOP/valid are single-cycle strobes.
module i2c_am_seq
    import i2c_am_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic byte_valid_i,
    input  logic ten_mode_i,
    input  logic hit_short_i,
    input  logic hit_hdr_i,
    input  logic hit_low_i,
    input  logic rd_bit_i,
    output logic ack_o,
    output logic matched_o,
    output logic dir_rd_o
);

    am_state_e state_q;
    logic      ack_q;
    logic      match_q;
    logic      dir_q;
    logic      hdr_dir_q;   // direction from the 10-bit header byte
    logic      ten_sel_q;   // current selection came from 10-bit addressing
    logic      armed_q;     // repeated-START read re-select allowed

    // Sequencer: START beats STOP, both beat a coincident byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ack_q     <= 1'b0;
            match_q   <= 1'b0;
            dir_q     <= 1'b0;
            hdr_dir_q <= 1'b0;
            ten_sel_q <= 1'b0;
            armed_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (start_i) begin
                state_q   <= ST_FIRST;
                match_q   <= 1'b0;
                dir_q     <= 1'b0;
                armed_q   <= match_q && ten_sel_q;
                ten_sel_q <= 1'b0;
            end else if (stop_i) begin
                state_q   <= ST_IDLE;
                match_q   <= 1'b0;
                dir_q     <= 1'b0;
                armed_q   <= 1'b0;
                ten_sel_q <= 1'b0;
            end else if (byte_valid_i) begin
                unique case (state_q)
                    ST_FIRST: begin
                        armed_q <= 1'b0;
                        if (ten_mode_i) begin
                            if (hit_hdr_i && armed_q && rd_bit_i) begin
                                ack_q     <= 1'b1;
                                match_q   <= 1'b1;
                                dir_q     <= 1'b1;
                                ten_sel_q <= 1'b1;
                                state_q   <= ST_ACTIVE;
                            end else if (hit_hdr_i) begin
                                ack_q     <= 1'b1;
                                hdr_dir_q <= rd_bit_i;
                                state_q   <= ST_SECOND;
                            end else begin
                                state_q   <= ST_IDLE;
                            end
                        end else if (hit_short_i) begin
                            ack_q   <= 1'b1;
                            match_q <= 1'b1;
                            dir_q   <= rd_bit_i;
                            state_q <= ST_ACTIVE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_SECOND: begin
                        if (hit_low_i) begin
                            ack_q     <= 1'b1;
                            match_q   <= 1'b1;
                            dir_q     <= hdr_dir_q;
                            ten_sel_q <= 1'b1;
                            state_q   <= ST_ACTIVE;
                        end else begin
                            state_q   <= ST_IDLE;
                        end
                    end
                    default: begin
                        state_q <= state_q;
                    end
                endcase
            end
        end
    end

    assign ack_o     = ack_q;
    assign matched_o = match_q;
    assign dir_rd_o  = dir_q;

endmodule

// File: rtl/i2c_addr_match.sv
// Module: top of the I2C target address recognizer. Captures configuration
// at START, compares address bytes, and sequences 7-bit and 10-bit address
// phases. Assumes an external shifter supplies strobes and whole bytes.
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              cfg_ten_bit_i,
    input  logic [ADDR_W-1:0] cfg_own_addr_i,
    output logic              ack_req_o,
    output logic              matched_o,
    output logic              dir_rd_o
);

    am_cfg_t cfg_snap;
    logic    hit_short;
    logic    hit_hdr;
    logic    hit_low;
    logic    rd_bit;

    i2c_am_cfg_latch u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ten_mode_i (cfg_ten_bit_i),
        .addr_i     (cfg_own_addr_i),
        .cfg_o      (cfg_snap)
    );

    i2c_am_cmp u_cmp (
        .byte_i      (byte_i),
        .cfg_i       (cfg_snap),
        .hit_short_o (hit_short),
        .hit_hdr_o   (hit_hdr),
        .hit_low_o   (hit_low),
        .rd_bit_o    (rd_bit)
    );

    i2c_am_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_valid_i (byte_valid_i),
        .ten_mode_i   (cfg_snap.ten_mode),
        .hit_short_i  (hit_short),
        .hit_hdr_i    (hit_hdr),
        .hit_low_i    (hit_low),
        .rd_bit_i     (rd_bit),
        .ack_o        (ack_req_o),
        .matched_o    (matched_o),
        .dir_rd_o     (dir_rd_o)
    );

endmodule

// File: rtl/i2c_am_chk.sv
// Checker: temporal properties of the address recognizer ports.
// Assumes synchronous active-low reset; bound into every i2c_addr_match.
module i2c_am_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic byte_valid_i,
    input logic ack_req_o,
    input logic matched_o,
    input logic dir_rd_o
);

    // R10/R11: an acknowledge only follows a byte that had no START/STOP beside it
    p_ack_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> $past(byte_valid_i && !start_i && !stop_i));

    // R8: STOP alone clears selection and direction
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (!matched_o && !dir_rd_o));

    // R8: START clears selection and direction
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!matched_o && !dir_rd_o));

    // R2: a read direction is only reported while selected
    p_dir_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rd_o |-> matched_o);

    // R5: selection begins together with an acknowledge
    p_match_with_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(matched_o) |-> ack_req_o);

endmodule

bind i2c_addr_match i2c_am_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .ack_req_o    (ack_req_o),
    .matched_o    (matched_o),
    .dir_rd_o     (dir_rd_o)
);

// File: tb/i2c_addr_match_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_match_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       stop_i;
    logic       byte_valid_i;
    logic [7:0] byte_i;
    logic       cfg_ten_bit_i;
    logic [9:0] cfg_own_addr_i;
    logic       ack_req_o;
    logic       matched_o;
    logic       dir_rd_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  ack;
        logic  mat;
        logic  dir;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    i2c_addr_match dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .stop_i         (stop_i),
        .byte_valid_i   (byte_valid_i),
        .byte_i         (byte_i),
        .cfg_ten_bit_i  (cfg_ten_bit_i),
        .cfg_own_addr_i (cfg_own_addr_i),
        .ack_req_o      (ack_req_o),
        .matched_o      (matched_o),
        .dir_rd_o       (dir_rd_o)
    );

    task automatic check3(input logic a, input logic m, input logic d, input string tag);
        checks++;
        if (ack_req_o !== a || matched_o !== m || dir_rd_o !== d) begin
            errors++;
            $display("FAIL %s: ack/match/dir actual %b%b%b expected %b%b%b",
                     tag, ack_req_o, matched_o, dir_rd_o, a, m, d);
        end
    endtask

    // Driver: push expectation, then present a byte (optionally with START/STOP)
    task automatic send(input logic [7:0] b, input logic st, input logic sp,
                        input logic ea, input logic em, input logic ed, input string tag);
        exp_t e;
        e.ack = ea; e.mat = em; e.dir = ed; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        byte_i = b; byte_valid_i = 1'b1; start_i = st; stop_i = sp;
        @(negedge clk);
        byte_valid_i = 1'b0; start_i = 1'b0; stop_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    // Monitor: compare each byte's result, then confirm the acknowledge dropped
    initial begin
        forever begin
            @(posedge clk);
            if (byte_valid_i) begin
                exp_t e;
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: actual result with no expected item");
                end else begin
                    e = exp_q.pop_front();
                    check3(e.ack, e.mat, e.dir, e.tag);
                    @(negedge clk);
                    checks++;
                    if (ack_req_o !== 1'b0) begin
                        errors++;
                        $display("FAIL R10 single-cycle ack (%s): actual %b expected 0", e.tag, ack_req_o);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; byte_valid_i = 1'b0;
        byte_i = 8'h00; cfg_ten_bit_i = 1'b0; cfg_own_addr_i = 10'h035;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check3(0, 0, 0, "R1 reset state");
        send(8'h6A, 0, 0, 0, 0, 0, "R1 byte before START ignored");

        // 7-bit write and read
        do_start();
        send(8'h6A, 0, 0, 1, 1, 0, "R2 7-bit write match");
        send(8'h6A, 0, 0, 0, 1, 0, "R10 no ack in data phase");
        do_stop();
        check3(0, 0, 0, "R8 STOP clears match");
        do_start();
        send(8'h6B, 0, 0, 1, 1, 1, "R2 7-bit read match");
        do_stop();
        check3(0, 0, 0, "R8 STOP clears direction");

        // 7-bit mismatch and reserved prefix
        do_start();
        send(8'h6C, 0, 0, 0, 0, 0, "R3 7-bit mismatch");
        send(8'h6A, 0, 0, 0, 0, 0, "R3 later byte ignored");
        do_stop();
        cfg_own_addr_i = 10'h078;
        do_start();
        send(8'hF0, 0, 0, 0, 0, 0, "R3 reserved prefix never matches");
        do_stop();

        // 10-bit addressing, own address 0x2B5
        cfg_ten_bit_i = 1'b1; cfg_own_addr_i = 10'h2B5;
        do_start();
        send(8'hF4, 0, 0, 1, 0, 0, "R4 10-bit header ack");
        send(8'hB5, 0, 0, 1, 1, 0, "R5 10-bit low byte match");
        do_start();
        check3(0, 0, 0, "R8 repeated START clears match");
        send(8'hF5, 0, 0, 1, 1, 1, "R7 re-select for read");
        send(8'hF5, 0, 0, 0, 1, 1, "R10 no ack after re-select");
        do_stop();
        check3(0, 0, 0, "R8 STOP after 10-bit read");

        do_start();
        send(8'hF4, 0, 0, 1, 0, 0, "R4 header before low mismatch");
        send(8'hB4, 0, 0, 0, 0, 0, "R5 low byte mismatch");
        send(8'hB5, 0, 0, 0, 0, 0, "R5 ignored after mismatch");
        do_stop();
        do_start();
        send(8'hF2, 0, 0, 0, 0, 0, "R6 header A9:A8 mismatch");
        send(8'hB5, 0, 0, 0, 0, 0, "R6 later byte ignored");
        do_stop();
        do_start();
        send(8'hB4, 0, 0, 0, 0, 0, "R6 header without prefix");
        do_stop();

        // Read header without prior match needs the low byte
        do_start();
        send(8'hF5, 0, 0, 1, 0, 0, "R4 read header unarmed");
        send(8'hB5, 0, 0, 1, 1, 1, "R5 direction from header");
        do_stop();

        // Re-select with write bit takes the full sequence
        do_start();
        send(8'hF4, 0, 0, 1, 0, 0, "R4 first match");
        send(8'hB5, 0, 0, 1, 1, 0, "R5 first match low");
        do_start();
        send(8'hF4, 0, 0, 1, 0, 0, "R7 write header after match needs low byte");
        send(8'hB5, 0, 0, 1, 1, 0, "R7 low byte completes write");
        do_stop();

        // Configuration change after START has no effect
        do_start();
        cfg_ten_bit_i = 1'b0; cfg_own_addr_i = 10'h035;
        send(8'hF4, 0, 0, 1, 0, 0, "R9 mode held at START");
        send(8'hB5, 0, 0, 1, 1, 0, "R9 address held at START");
        do_stop();
        do_start();
        cfg_own_addr_i = 10'h036;
        send(8'h6A, 0, 0, 1, 1, 0, "R9 7-bit address held at START");
        do_stop();
        cfg_own_addr_i = 10'h035;

        // Strobe priorities
        send(8'h6A, 1, 1, 0, 0, 0, "R11 byte with START+STOP ignored");
        send(8'h6A, 0, 0, 1, 1, 0, "R11 START wins over STOP");
        send(8'h6A, 1, 0, 0, 0, 0, "R11 byte with START ignored");
        send(8'h6B, 0, 0, 1, 1, 1, "R11 first slot still open");
        do_stop();

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule